// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detect

This block gives a processor control of up to six banks of 32 general-purpose pins through a plain 32-bit register bus. Software reads the pin levels, chooses per pin whether the block drives the pad, and changes driven values only through separate write-one-to-set and write-one-to-clear registers. No read-modify-write is needed, so two agents that touch different pins in the same bank cannot undo each other's work.

Each pad input passes through a multi-flop synchroniser. A transition of the synchronised level is captured into a sticky per-pin status bit when the matching rising or falling enable is on. Software clears a status bit by writing a one to it. One interrupt line is high while any status bit in any bank is set. The last bank may carry fewer than 32 pins. A parameter mask marks pins whose direction bit has the reverse meaning.

The register file is decoded by address. Each register kind has its own block of addresses, and banks sit at consecutive words within that block. Banks 3 to 5 repeat the layout of banks 0 to 2 one page higher.

Top module: `banked_pin_ctrl`

## Requirements
- R1: Register address = (bank/3)*0x100 + kind*0x0C + (bank%3)*4, where kind is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. Any other address reads 0, and a write to it changes nothing.
- R2: A write to a bank's set register makes every pin whose data bit is 1 drive high on pad_out from the next cycle. Pins with a 0 data bit keep their value. The set register reads as 0.
- R3: A write to a bank's clear register makes every pin whose data bit is 1 drive low. Pins with a 0 data bit keep their value. The clear register reads as 0.
- R4: For a normal pin, direction bit 1 makes pad_oe 1. For a pin flagged in INV_DIR_MASK, direction bit 1 makes pad_oe 0. At reset each direction bit takes the value of its flag, so every pin starts as an input.
- R5: The level register returns the synchronised pad_in value of every pin, whether or not the pin is an output. A change on pad_in shows in the level register after the second rising clock edge. Writes to the level register are ignored.
- R6: When rising enable is 1 for a pin, a low-to-high change of its synchronised level sets its status bit. The bit is visible after the third rising edge following the pad_in change.
- R7: When falling enable is 1 for a pin, a high-to-low change sets its status bit. A change whose direction is not enabled does not set it. With both enables on, both directions set it.
- R8: A status bit stays set until a 1 is written to it in the status register. Writing 0xFFFFFFFF clears every status bit of the bank.
- R9: If a status clear and a new enabled edge hit the same bit on the same clock edge, the bit stays set.
- R10: irq is 1 exactly when at least one status bit in any bank is 1.
- R11: In the last bank, the bits at and above LAST_PINS read as 0 in every register and ignore writes.
- R12: After reset: pad_out all 0, irq 0, all enables and status 0, and every pin an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Output latch value per pin |
| pad_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
A wrong output latch or direction bit shows on pad_out or pad_oe on the cycle after the write that caused it, so pin checks follow each write directly. Faults in the synchroniser or the edge detector are timing faults. A shortened pipe, or a level compared against the wrong earlier value, shows up as a status bit or an irq change that is a cycle early or late, or that is missing. The bench therefore reads status and level at fixed distances from a pad change. The same-edge case of clear and capture is driven to the exact clock edge, because a design that lets the clear win drops the event without any other visible sign.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

   localparam int BANK_W       = 32;
   localparam int NUM_KINDS    = 7;
   localparam int KIND_STRIDE  = 12;
   localparam int LANE_STRIDE  = 4;
   localparam int GROUP_BANKS  = 3;
   localparam int GROUP_STRIDE = 256;
   localparam int MAX_BANKS    = 6;

   // Register kind index: offset = kind * KIND_STRIDE inside a group
   typedef enum logic [2:0] {
      K_LEVEL = 3'd0,
      K_DIR   = 3'd1,
      K_SET   = 3'd2,
      K_CLR   = 3'd3,
      K_RISE  = 3'd4,
      K_FALL  = 3'd5,
      K_STAT  = 3'd6
   } reg_kind_e;

   typedef struct packed {
      logic [BANK_W-1:0] level;
      logic [BANK_W-1:0] dir;
      logic [BANK_W-1:0] rise;
      logic [BANK_W-1:0] fall;
      logic [BANK_W-1:0] stat;
   } bank_view_t;

   function automatic int unsigned reg_offset(input int unsigned bank, input int unsigned kind);
      return (bank / GROUP_BANKS) * GROUP_STRIDE
           + kind * KIND_STRIDE
           + (bank % GROUP_BANKS) * LANE_STRIDE;
   endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pinctl_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pinctl_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pinctl_decode.sv
module pinctl_decode
   import pinctl_pkg::*;
#(
   parameter int NUM_BANKS = 6,
   parameter int ADDR_W    = 12,
   parameter int BSEL_W    = 3
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [BSEL_W-1:0] bank_sel,
   output reg_kind_e         kind_sel
);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("pinctl_decode: NUM_BANKS out of range");
   end
   if ((1 << BSEL_W) < NUM_BANKS) begin : g_bad_bsel
      $error("pinctl_decode: BSEL_W too narrow");
   end

   always_comb begin
      hit      = 1'b0;
      bank_sel = '0;
      kind_sel = K_LEVEL;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int k = 0; k < NUM_KINDS; k++) begin
            if (addr == ADDR_W'(reg_offset(b, k))) begin
               hit      = 1'b1;
               bank_sel = BSEL_W'(b);
               kind_sel = reg_kind_e'(3'(k));
            end
         end
      end
   end

endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
   import pinctl_pkg::*;
#(
   parameter int          PINS        = 32,
   parameter logic [31:0] INV_MASK    = '0,
   parameter int          SYNC_STAGES = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_KINDS-1:0] wr_kind,
   input  logic [31:0]          wdata,
   input  logic [PINS-1:0]      pad_in,
   output logic [PINS-1:0]      pad_out,
   output logic [PINS-1:0]      pad_oe,
   output bank_view_t           view,
   output logic                 evt_any
);

   if (PINS < 1 || PINS > BANK_W) begin : g_bad_pins
      $error("pinctl_bank: PINS must be 1..32");
   end

   localparam logic [PINS-1:0] INV = INV_MASK[PINS-1:0];

   logic [PINS-1:0] lvl_now, lvl_prev;
   logic [PINS-1:0] out_q, dir_q, rise_q, fall_q, stat_q;
   logic [PINS-1:0] wd, hit_vec, clr_vec;

   pinctl_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (lvl_now)
   );

   assign wd      = wdata[PINS-1:0];
   assign hit_vec = (lvl_now & ~lvl_prev & rise_q) | (~lvl_now & lvl_prev & fall_q);
   assign clr_vec = wr_kind[K_STAT] ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         out_q    <= '0;
         dir_q    <= INV;
         rise_q   <= '0;
         fall_q   <= '0;
         stat_q   <= '0;
      end else begin
         lvl_prev <= lvl_now;
         if (wr_kind[K_SET])       out_q <= out_q | wd;
         else if (wr_kind[K_CLR])  out_q <= out_q & ~wd;
         if (wr_kind[K_DIR])  dir_q  <= wd;
         if (wr_kind[K_RISE]) rise_q <= wd;
         if (wr_kind[K_FALL]) fall_q <= wd;
         stat_q <= (stat_q & ~clr_vec) | hit_vec;
      end
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q ^ INV;
   assign evt_any = |stat_q;

   assign view.level = 32'(lvl_now);
   assign view.dir   = 32'(dir_q);
   assign view.rise  = 32'(rise_q);
   assign view.fall  = 32'(fall_q);
   assign view.stat  = 32'(stat_q);

   // R2
   set_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kind[K_SET] |=> ((pad_out & $past(wd)) == $past(wd)));

   // R3
   clr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kind[K_CLR] |=> ((pad_out & $past(wd)) == '0));

   // R4
   oe_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kind[K_DIR] |=> (pad_oe == ($past(wd) ^ INV)));

   // R8
   stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_kind[K_STAT] |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R6
   stat_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec != '0) |=> ((stat_q & $past(hit_vec)) == $past(hit_vec)));

   // R8
   stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kind[K_STAT] |=> ((stat_q & $past(wd & ~hit_vec)) == '0));

endmodule

// File: rtl/banked_pin_ctrl.sv
module banked_pin_ctrl
   import pinctl_pkg::*;
#(
   parameter int                      NUM_BANKS    = 6,
   parameter int                      LAST_PINS    = 32,
   parameter int                      ADDR_W       = 12,
   parameter int                      SYNC_STAGES  = 2,
   parameter logic [NUM_BANKS*32-1:0] INV_DIR_MASK = '0,
   localparam int                     NPINS        = (NUM_BANKS - 1) * 32 + LAST_PINS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);

   localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("banked_pin_ctrl: NUM_BANKS must be 1..6");
   end
   if (LAST_PINS < 1 || LAST_PINS > BANK_W) begin : g_bad_last
      $error("banked_pin_ctrl: LAST_PINS must be 1..32");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("banked_pin_ctrl: ADDR_W must be at least 9");
   end

   logic              hit;
   logic [BSEL_W-1:0] bank_sel;
   reg_kind_e         kind_sel;
   bank_view_t        view [NUM_BANKS];
   logic [NUM_BANKS-1:0] evt;

   pinctl_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BSEL_W(BSEL_W)) dec_i (
      .addr     (bus_addr),
      .hit      (hit),
      .bank_sel (bank_sel),
      .kind_sel (kind_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int W  = (b == NUM_BANKS - 1) ? LAST_PINS : BANK_W;
      localparam int LO = b * BANK_W;
      logic [NUM_KINDS-1:0] wr_kind;

      assign wr_kind = (bus_wr && hit && bank_sel == BSEL_W'(b))
                     ? (NUM_KINDS'(1) << kind_sel) : '0;

      pinctl_bank #(
         .PINS        (W),
         .INV_MASK    (INV_DIR_MASK[LO +: 32]),
         .SYNC_STAGES (SYNC_STAGES)
      ) bank_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_kind (wr_kind),
         .wdata   (bus_wdata),
         .pad_in  (pad_in[LO +: W]),
         .pad_out (pad_out[LO +: W]),
         .pad_oe  (pad_oe[LO +: W]),
         .view    (view[b]),
         .evt_any (evt[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (kind_sel)
            K_LEVEL: bus_rdata = view[bank_sel].level;
            K_DIR:   bus_rdata = view[bank_sel].dir;
            K_RISE:  bus_rdata = view[bank_sel].rise;
            K_FALL:  bus_rdata = view[bank_sel].fall;
            K_STAT:  bus_rdata = view[bank_sel].stat;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign irq = |evt;

   // R1
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (bus_rdata == '0));

   // R2
   set_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (kind_sel == K_SET || kind_sel == K_CLR)) |-> (bus_rdata == '0));

endmodule

// File: tb/banked_pin_ctrl_tb.sv
module banked_pin_ctrl_tb_top;

   localparam int CLK_P     = 10;
   localparam int NB        = 6;
   localparam int LASTP     = 20;
   localparam int AW        = 12;
   localparam int NP        = (NB - 1) * 32 + LASTP;
   localparam logic [NB*32-1:0] INV = (192'd1 << 5) | (192'd1 << 40);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          src;   // 0 rdata, 1 pad_out bit, 2 pad_oe bit, 3 irq
      int          idx;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   always #(CLK_P/2) clk = ~clk;

   banked_pin_ctrl #(
      .NUM_BANKS(NB), .LAST_PINS(LASTP), .ADDR_W(AW), .SYNC_STAGES(2), .INV_DIR_MASK(INV)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   localparam int KL = 0, KD = 1, KS = 2, KC = 3, KR = 4, KF = 5, KT = 6;

   function automatic int ra(input int bank, input int kind);
      int grp = (bank >= 3) ? 'h100 : 0;
      return grp + kind * 'hC + (bank % 3) * 4;
   endfunction

   // monitor: compares what the driver queued
   always @(negedge clk) begin
      #2;
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.src)
            0:       act = bus_rdata;
            1:       act = {31'b0, pad_out[it.idx]};
            2:       act = {31'b0, pad_oe[it.idx]};
            default: act = {31'b0, irq};
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic chk_rd(input int a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_addr = AW'(a);
      #1;
      sb_q.push_back('{0, 0, e, tag});
   endtask

   task automatic chk_sig(input int src, input int idx, input logic [31:0] e, input string tag);
      @(negedge clk);
      #1;
      sb_q.push_back('{src, idx, e, tag});
   endtask

   task automatic pad(input int idx, input logic v);
      @(negedge clk);
      pad_in[idx] = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state, R4 reset direction follows inversion flags
      chk_sig(3, 0, 32'd0, "R12 irq after reset");
      chk_sig(1, 0, 32'd0, "R12 pad_out after reset");
      chk_sig(2, 5, 32'd0, "R4 inverted pin input at reset");
      chk_sig(2, 40, 32'd0, "R4 inverted pin 40 input at reset");
      chk_rd(ra(0, KD), 32'h0000_0020, "R4 bank0 dir reset");
      chk_rd(ra(1, KD), 32'h0000_0100, "R4 bank1 dir reset");
      chk_rd(ra(3, KT), 32'h0, "R12 bank3 status reset");

      // R4 direction polarity
      wr(ra(0, KD), 32'h0000_000F);
      chk_sig(2, 0, 32'd1, "R4 normal pin dir1 is output");
      chk_sig(2, 4, 32'd0, "R4 normal pin dir0 is input");
      chk_sig(2, 5, 32'd1, "R4 inverted pin dir0 is output");

      // R2 / R3 set and clear
      wr(ra(0, KS), 32'h0000_0005);
      chk_sig(1, 0, 32'd1, "R2 set bit0");
      chk_sig(1, 1, 32'd0, "R2 zero bit untouched");
      wr(ra(0, KS), 32'h0000_0002);
      chk_sig(1, 2, 32'd1, "R2 earlier set kept");
      wr(ra(0, KC), 32'h0000_0001);
      chk_sig(1, 0, 32'd0, "R3 clear bit0");
      chk_sig(1, 1, 32'd1, "R3 zero bit untouched");
      chk_rd(ra(0, KS), 32'h0, "R2 set reg reads zero");
      chk_rd(ra(0, KC), 32'h0, "R3 clear reg reads zero");

      // R1 interleaved layout
      wr(ra(4, KS), 32'h0000_0001);
      chk_sig(1, 128, 32'd1, "R1 bank4 set at 0x104+0x18");
      wr(ra(1, KS), 32'h0000_0008);
      chk_sig(1, 35, 32'd1, "R1 bank1 set");
      chk_sig(1, 3, 32'd0, "R1 bank0 untouched");

      // R5 level, visible regardless of direction, writes ignored
      pad(70, 1'b1);
      chk_rd(ra(2, KL), 32'h0000_0040, "R5 bank2 level");
      pad(1, 1'b1);
      chk_rd(ra(0, KL), 32'h0000_0002, "R5 level of output pin");
      wr(ra(2, KL), 32'hFFFF_FFFF);
      chk_rd(ra(2, KL), 32'h0000_0040, "R5 level write ignored");

      // R6 rising edge and R10 irq
      wr(ra(1, KR), 32'h0000_0001);
      pad(32, 1'b1);
      chk_rd(ra(1, KT), 32'h0000_0001, "R6 rise captured");
      chk_sig(3, 0, 32'd1, "R10 irq high");
      wr(ra(1, KT), 32'h0000_0001);
      chk_rd(ra(1, KT), 32'h0, "R8 w1c clears");
      chk_sig(3, 0, 32'd0, "R10 irq low");

      // R7 falling edge
      pad(32, 1'b0);
      chk_rd(ra(1, KT), 32'h0, "R7 fall ignored when disabled");
      wr(ra(1, KF), 32'h0000_0001);
      pad(32, 1'b1);
      chk_rd(ra(1, KT), 32'h0000_0001, "R7 rise with both enabled");
      wr(ra(1, KT), 32'h0000_0001);
      pad(32, 1'b0);
      chk_rd(ra(1, KT), 32'h0000_0001, "R7 fall with both enabled");
      chk_rd(ra(1, KT), 32'h0000_0001, "R8 status sticky");
      wr(ra(1, KT), 32'hFFFF_FFFF);
      chk_rd(ra(1, KT), 32'h0, "R8 all ones clears bank");

      // R9 clear and edge on the same clock edge
      pad(32, 1'b1);
      @(negedge clk);
      pad_in[32] = 1'b0;
      @(negedge clk);
      wr(ra(1, KT), 32'h0000_0001);
      chk_rd(ra(1, KT), 32'h0000_0001, "R9 edge wins over clear");
      wr(ra(1, KT), 32'h0000_0001);
      chk_rd(ra(1, KT), 32'h0, "R9 later clear works");

      // R11 partial last bank
      wr(ra(5, KD), 32'hFFFF_FFFF);
      chk_rd(ra(5, KD), 32'h000F_FFFF, "R11 last bank dir width");
      chk_sig(2, 179, 32'd1, "R11 top pin output");
      wr(ra(5, KR), 32'hFFFF_FFFF);
      chk_rd(ra(5, KR), 32'h000F_FFFF, "R11 last bank rise width");

      // R1 unmapped
      wr('h0E0, 32'hFFFF_FFFF);
      chk_rd(ra(0, KD), 32'h0000_000F, "R1 unmapped write ignored");
      chk_sig(1, 4, 32'd0, "R1 unmapped write no output");
      chk_rd('h0E0, 32'h0, "R1 unmapped read");
      chk_rd('h154, 32'h0, "R1 beyond last status");
      chk_rd('h002, 32'h0, "R1 misaligned read");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule